// File: doc/BRIEF.md
# Selectable Registered / Flow-Through Read Output Stage

This block sits between the read port of a synchronous memory array and the tri-state data pins. Each clock edge it samples a command (idle/deselect, read or write). It then decides in which cycle the array's read data reaches the bus, and whether the bus is driven at all. The bus is modelled as a data vector plus one drive flag per byte lane. A static mode input chooses the path. In registered mode the array data goes through a rising-edge output register, which gives a 3-1-1-1 burst profile. In flow-through mode the array data goes straight to the bus, which gives 2-1-1-1.

A deselect moves through the same two stages as a read. The bus therefore keeps showing the last read result for one full cycle after a deselect, and it releases only after the second rising edge. An active-low output enable removes drive at once, with no clock involved. A write cycle always leaves the bus undriven. An active-high sleep input turns off all drive, makes the block ignore commands, stops the hold register from loading, and flushes the stages. After wake-up, nothing is driven until a new read has gone through.

Top module: `rdOutStage`

## Requirements
- R1: While reset is asserted and right after it is released, no byte lane is driven and the data bus reads zero.
- R2: Registered mode (pipeMode=1). A read command sampled at edge k makes the bus present, in the cycle after edge k+1, the array data that was applied in the cycle between edges k and k+1. Back-to-back reads give one new word per cycle after that.
- R3: Flow-through mode (pipeMode=0). In the cycle after the edge that samples a read, the bus follows arrData combinationally, one cycle earlier than in R2.
- R4: A deselect sampled directly after a read keeps the bus driven with that read's data for one more cycle in both modes. Drive stops only after the next edge. Command codes: 2'b00 idle/deselect, 2'b01 read, 2'b10 write, and 2'b11 acts as deselect.
- R5: In the cycle after a write command has been sampled, no lane is driven. This holds in both modes, even when a registered read result is pending.
- R6: oeN high removes all drive in the same cycle, with no clock edge. oeN low enables drive only in cycles where R2 to R4 call for a read result.
- R7: All byte lanes are driven together or not at all. When no lane is driven the data bus reads zero.
- R8: While sleep is high, no lane is driven and commands are ignored. After sleep falls, nothing is driven until a read issued after wake-up reaches the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeMode | input | 1 | 1 = registered output, 0 = flow-through |
| sleep | input | 1 | Active-high low-power standby |
| cmd | input | 2 | Command sampled each edge: 00 idle, 01 read, 10 write, 11 idle |
| arrData | input | DATA_W | Array read data, valid in the cycle after a read is sampled |
| oeN | input | 1 | Asynchronous active-low output enable |
| busData | output | DATA_W | Data presented to the pads, zero when undriven |
| busOe | output | DATA_W/LANE_W | Per-lane drive enable |

## Verification
The bench runs a read that is followed by a deselect, by a write, or by a 2'b11 code. A design that released the bus one edge early, or that drove stale data in the cycle after the deselect, fails the R4 checks. It drops oeN in the middle of a cycle while a result is due, and it holds oeN low through idle cycles. This catches both a clocked output enable and an enable that drives on its own. Sleep is raised while a result is still in flight. A design that kept its stage registers, or let the hold register load, would show old data after wake-up. A read followed by a write in registered mode catches a design that lets a pending result collide with write data.

// File: rtl/rdOutPkg.sv
package rdOutPkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  typedef struct packed {
    logic capEn;    // load hold register from array
    logic useLive;  // present array data directly
    logic drvReq;   // a read result is due on the bus
  } outStrobe_t;

  function automatic cmd_e normCmd(input logic [1:0] raw);
    case (raw)
      2'b01:   return CMD_READ;
      2'b10:   return CMD_WRITE;
      default: return CMD_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rdOutCtrl.sv
module rdOutCtrl
  import rdOutPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeMode,
  input  logic       sleep,
  input  logic [1:0] cmd,
  output outStrobe_t strb
);

  cmd_e stage1Q;
  cmd_e stage2Q;
  logic pipeDrv;
  logic flowDrv;

  // two command stages; sleep flushes them so nothing stale survives wake-up
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Q <= CMD_NONE;
      stage2Q <= CMD_NONE;
    end else if (sleep) begin
      stage1Q <= CMD_NONE;
      stage2Q <= CMD_NONE;
    end else begin
      stage1Q <= normCmd(cmd);
      stage2Q <= stage1Q;
    end
  end

  always_comb begin
    // registered: result from two edges back, unless a write is in its data cycle
    pipeDrv = (stage2Q == CMD_READ) && (stage1Q != CMD_WRITE);
    // flow-through: live read, or the extra hold cycle after a deselect
    flowDrv = (stage1Q == CMD_READ) ||
              ((stage1Q == CMD_NONE) && (stage2Q == CMD_READ));

    strb.capEn   = !sleep && (stage1Q == CMD_READ);
    strb.useLive = !pipeMode && (stage1Q == CMD_READ);
    strb.drvReq  = !sleep && (pipeMode ? pipeDrv : flowDrv);
  end

endmodule

// File: rtl/rdOutData.sv
module rdOutData
  import rdOutPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  outStrobe_t                 strb,
  input  logic                       oeN,
  input  logic [DATA_W-1:0]          arrData,
  output logic [DATA_W-1:0]          busData,
  output logic [DATA_W/LANE_W-1:0]   busOe
);

  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] holdQ;
  logic [DATA_W-1:0] srcData;
  logic              laneOn;

  always_ff @(posedge clk) begin
    if (!rstN)
      holdQ <= '0;
    else if (strb.capEn)
      holdQ <= arrData;
  end

  assign srcData = strb.useLive ? arrData : holdQ;
  // output enable acts without any clock
  assign laneOn  = strb.drvReq && !oeN;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign busOe[g] = laneOn;
    assign busData[g*LANE_W +: LANE_W] =
      laneOn ? srcData[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/rdOutStage.sv
module rdOutStage
  import rdOutPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pipeMode,
  input  logic                      sleep,
  input  logic [1:0]                cmd,
  input  logic [DATA_W-1:0]         arrData,
  input  logic                      oeN,
  output logic [DATA_W-1:0]         busData,
  output logic [DATA_W/LANE_W-1:0]  busOe
);

  outStrobe_t strb;

  rdOutCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pipeMode (pipeMode),
    .sleep    (sleep),
    .cmd      (cmd),
    .strb     (strb)
  );

  rdOutData #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .oeN     (oeN),
    .arrData (arrData),
    .busData (busData),
    .busOe   (busOe)
  );

endmodule

// File: rtl/rdOutStageChk.sv
module rdOutStageChk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      pipeMode,
  input logic                      sleep,
  input logic [1:0]                cmd,
  input logic [DATA_W-1:0]         arrData,
  input logic                      oeN,
  input logic [DATA_W-1:0]         busData,
  input logic [DATA_W/LANE_W-1:0]  busOe
);

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (busOe == '0));

  // R8
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (busOe == '0));

  // R7
  lanes_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe == '0) || (&busOe));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe == '0) |-> (busData == '0));

  // R5
  write_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == 2'b10 && !$past(sleep)) |-> (busOe == '0));

  // R2
  pipe_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(rstN) && $past(rstN, 2) && $past(cmd, 2) == 2'b01 &&
     $past(cmd) != 2'b10 && !$past(sleep) && !$past(sleep, 2) && !sleep && !oeN)
    |-> ((&busOe) && busData == $past(arrData)));

  // R3
  flow_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(rstN) && $past(cmd) == 2'b01 && !$past(sleep) &&
     !sleep && !oeN) |-> ((&busOe) && busData == arrData));

  // R4
  dcd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(cmd, 2) == 2'b01 &&
     ($past(cmd) == 2'b00 || $past(cmd) == 2'b11) &&
     !$past(sleep) && !$past(sleep, 2) && !sleep && !oeN) |-> (&busOe));

endmodule

bind rdOutStage rdOutStageChk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pipeMode (pipeMode),
  .sleep    (sleep),
  .cmd      (cmd),
  .arrData  (arrData),
  .oeN      (oeN),
  .busData  (busData),
  .busOe    (busOe)
);

// File: tb/tb_rdOutStage.sv
`timescale 1ns/1ps
module tb_rdOutStage;

  localparam int DATA_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;
  localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_SP = 2'b11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pipeMode = 1'b1;
  logic              sleep = 1'b0;
  logic [1:0]        cmd = C_IDLE;
  logic [DATA_W-1:0] arrData = '0;
  logic              oeN = 1'b0;
  logic [DATA_W-1:0] busData;
  logic [LANES-1:0]  busOe;

  int checks = 0;
  int errors = 0;

  // bench model of what has been sampled
  logic [1:0]        h1 = C_IDLE;
  logic [1:0]        h2 = C_IDLE;
  logic [DATA_W-1:0] hData = '0;

  always #5 clk = ~clk;

  rdOutStage #(.DATA_W(DATA_W), .LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .sleep(sleep), .cmd(cmd),
    .arrData(arrData), .oeN(oeN), .busData(busData), .busOe(busOe)
  );

  function automatic logic [1:0] norm(input logic [1:0] c);
    return (c == C_RD || c == C_WR) ? c : C_IDLE;
  endfunction

  task automatic expectBus(input logic expDrv, input logic [DATA_W-1:0] expData,
                           input string tag);
    logic [LANES-1:0]  eOe;
    logic [DATA_W-1:0] eData;
    eOe   = expDrv ? '1 : '0;
    eData = expDrv ? expData : '0;
    checks++;
    if (busOe !== eOe || busData !== eData) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
               tag, busOe, busData, eOe, eData);
    end
  endtask

  // one cycle: apply inputs at negedge, check, then advance the model over the edge
  task automatic cyc(input logic [1:0] c, input logic [DATA_W-1:0] d,
                     input logic oe, input logic slp, input string tag);
    logic drv;
    logic [DATA_W-1:0] exp;
    cmd = c; arrData = d; oeN = oe; sleep = slp;
    #1;
    if (pipeMode) begin
      drv = (h2 == C_RD) && (h1 != C_WR);
      exp = hData;
    end else begin
      drv = (h1 == C_RD) || (h1 == C_IDLE && h2 == C_RD);
      exp = (h1 == C_RD) ? d : hData;
    end
    drv = drv && !oe && !slp;
    expectBus(drv, exp, tag);
    @(posedge clk);
    if (slp) begin
      h1 = C_IDLE; h2 = C_IDLE;
    end else begin
      if (h1 == C_RD) hData = d;
      h2 = h1;
      h1 = norm(c);
    end
    @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R6");
  endtask

  task automatic doReset();
    rstN = 1'b0; cmd = C_IDLE; sleep = 1'b0; oeN = 1'b0;
    repeat (3) @(negedge clk);
    expectBus(1'b0, '0, "R1");
    rstN = 1'b1;
    h1 = C_IDLE; h2 = C_IDLE; hData = '0;
    cyc(C_IDLE, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1");
  endtask

  // R2: registered burst, data two edges after the command
  task automatic scnPipeBurst();
    pipeMode = 1'b1; flush();
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R2");
    cyc(C_RD, 32'hA0A0_0001, 1'b0, 1'b0, "R2");
    cyc(C_RD, 32'hA0A0_0002, 1'b0, 1'b0, "R2");
    cyc(C_RD, 32'hA0A0_0003, 1'b0, 1'b0, "R2");
    cyc(C_IDLE, 32'hA0A0_0004, 1'b0, 1'b0, "R2");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R4");
  endtask

  // R3: flow-through burst follows the array one cycle earlier
  task automatic scnFlowBurst();
    pipeMode = 1'b0; flush();
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R3");
    cyc(C_RD, 32'hB1B1_0001, 1'b0, 1'b0, "R3");
    cyc(C_RD, 32'hB1B1_0002, 1'b0, 1'b0, "R3");
    cyc(C_RD, 32'hB1B1_0003, 1'b0, 1'b0, "R3");
    cyc(C_IDLE, 32'hB1B1_0004, 1'b0, 1'b0, "R3");
    cyc(C_IDLE, 32'hDEAD_BEEF, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R4");
  endtask

  // R4: deselect holds the bus one cycle; 2'b11 acts as deselect
  task automatic scnDeselect(input logic m);
    pipeMode = m; flush();
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R4");
    cyc(C_SP, 32'hC3C3_1234, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h5555_5555, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h6666_6666, 1'b0, 1'b0, "R4");
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'hC3C3_5678, 1'b0, 1'b0, "R4");
    cyc(C_RD, 32'h7777_7777, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'hC3C3_9ABC, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R4");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R4");
  endtask

  // R5: writes leave the bus undriven, even with a registered result pending
  task automatic scnWrite(input logic m);
    pipeMode = m; flush();
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R5");
    cyc(C_WR, 32'hD4D4_0001, 1'b0, 1'b0, "R5");
    cyc(C_WR, 32'h1111_2222, 1'b0, 1'b0, "R5");
    cyc(C_IDLE, 32'h3333_4444, 1'b0, 1'b0, "R5");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R5");
  endtask

  // R6/R7: oeN acts mid-cycle; idle with oeN low stays undriven
  task automatic scnOe();
    pipeMode = 1'b0; flush();
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R6");
    cyc(C_RD, 32'h0, 1'b1, 1'b0, "R6");
    cmd = C_IDLE; arrData = 32'hE5E5_0001; oeN = 1'b0;
    #1 expectBus(1'b1, 32'hE5E5_0001, "R7");
    oeN = 1'b1;
    #1 expectBus(1'b0, '0, "R6");
    oeN = 1'b0;
    #1 expectBus(1'b1, 32'hE5E5_0001, "R6");
    @(posedge clk);
    hData = 32'hE5E5_0001; h2 = C_RD; h1 = C_IDLE;
    @(negedge clk);
    cyc(C_IDLE, 32'h0, 1'b1, 1'b0, "R6");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R6");
  endtask

  // R8: sleep kills drive, ignores commands, leaves nothing stale
  task automatic scnSleep(input logic m);
    pipeMode = m; flush();
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R8");
    cyc(C_RD, 32'hF6F6_0001, 1'b0, 1'b1, "R8");
    cyc(C_RD, 32'hF6F6_0002, 1'b0, 1'b1, "R8");
    cyc(C_IDLE, 32'hF6F6_0003, 1'b0, 1'b0, "R8");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R8");
    cyc(C_RD, 32'h0, 1'b0, 1'b0, "R8");
    cyc(C_IDLE, 32'hF6F6_0004, 1'b0, 1'b0, "R8");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R8");
    cyc(C_IDLE, 32'h0, 1'b0, 1'b0, "R8");
  endtask

  initial begin
    @(negedge clk);
    doReset();
    scnPipeBurst();
    scnFlowBurst();
    scnDeselect(1'b1);
    scnDeselect(1'b0);
    scnWrite(1'b1);
    scnWrite(1'b0);
    scnOe();
    scnSleep(1'b1);
    scnSleep(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule